// File: doc/BRIEF.md
# Multi-Channel Level and Edge Trigger Matcher

This block watches a word of sampled logic channels and raises a single-cycle trigger pulse when every participating channel meets its own condition on the same sample strobe. Each channel's condition is spread across four mask inputs. The participate mask and the enable mask together decide whether the channel takes part. The level mask selects between a steady-value test and a transition test. The polarity mask then means "high" for a level channel and "falling" for an edge channel, or "low" and "rising" when the bit is clear.

A capture sequencer arms the block with a one-cycle pulse and then waits for the trigger. An edge is judged between the current strobed sample and the previous strobed sample. Arming discards the stored sample, so the first strobe after arming can never show an edge. If no channel is enabled, the block fires on the first strobe after arming, so capture does not wait. After it fires, the block stays quiet until it is armed again.

Top module: `trig_match`

## Requirements
- R1: After reset `trig_o` is 0 and the block is disarmed; strobes that arrive before the first `arm_i` pulse never produce a trigger.
- R2: Bit i of every mask belongs to channel i of `sample_i`. A channel whose level bit is 1 matches when its sample bit equals its polarity bit (1 = high, 0 = low).
- R3: A channel whose level bit is 0 matches on a transition between the previous strobed sample and the current one: polarity 1 means 1 to 0 (falling), and polarity 0 means 0 to 1 (rising).
- R4: The trigger fires only when all channels with both their participate bit and their enable bit set match on the same strobe. Channels with either bit clear have no effect.
- R5: With the enable mask all zero, the first strobe after arming fires the trigger, whatever the sample value.
- R6: Arming clears the stored previous sample, so no edge channel matches on the first strobe after `arm_i`.
- R7: The trigger is a one-cycle pulse on `trig_o` in the cycle after the matching strobe. Once it has fired, no further strobe fires until the next `arm_i` pulse.
- R8: When `arm_i` and `strobe_i` are high in the same cycle, arming wins. That strobe is neither evaluated nor stored as the previous sample.
- R9: Cycles without `strobe_i` neither evaluate nor update the stored sample, so edges are measured from strobe to strobe, not from clock to clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | One-cycle pulse that arms the matcher and clears the sample history |
| strobe_i | input | 1 | Qualifies `sample_i` as a new sample |
| sample_i | input | 16 | Sampled channel values, bit i = channel i |
| chan_mask_i | input | 16 | Channel participates when set |
| en_mask_i | input | 16 | Trigger condition enabled for the channel when set |
| level_mask_i | input | 16 | 1 = level condition, 0 = edge condition |
| pol_mask_i | input | 16 | Level: 1 high, 0 low; edge: 1 falling, 0 rising |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The collision of interest is an arm pulse landing on the same cycle as a sample strobe. The bench forces this twice. Once it is done with no channel enabled, where an evaluated strobe would fire at once. Once it is done with a rising-edge channel, where a stored strobe of 0 would turn the next strobe of 1 into a valid edge. In both cases `trig_o` must stay low after the coincident cycle. In the second case the following strobe must also stay quiet, because it is the first strobe after arming. A correct design is thereby told apart from one that evaluates or records the coincident strobe.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned DEF_NUM_CH = 16;

  typedef enum logic [1:0] {
    COND_LOW  = 2'b00,
    COND_HIGH = 2'b01,
    COND_RISE = 2'b10,
    COND_FALL = 2'b11
  } cond_e;

  function automatic cond_e decode_cond(input logic level, input logic pol);
    case ({level, pol})
      2'b11:   return COND_HIGH;
      2'b10:   return COND_LOW;
      2'b01:   return COND_FALL;
      default: return COND_RISE;
    endcase
  endfunction

  function automatic logic cond_hit(input cond_e kind, input logic cur,
                                    input logic prev, input logic prev_ok);
    case (kind)
      COND_HIGH: return cur;
      COND_LOW:  return !cur;
      COND_RISE: return prev_ok && !prev && cur;
      default:   return prev_ok && prev && !cur;
    endcase
  endfunction
endpackage

// File: rtl/trig_hist.sv
module trig_hist #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      q_o     <= d_i;
      valid_o <= 1'b1;
    end
  end

  // R6
  hist_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);

  // R9
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i) |=> $stable(q_o) && $stable(valid_o));
endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import trig_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic         prev_ok_i,
  input  logic [W-1:0] need_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] pol_i,
  output logic         all_o
);
  logic [W-1:0] ok;

  for (genvar g = 0; g < W; g++) begin : g_ch
    cond_e kind;
    assign kind  = decode_cond(level_i[g], pol_i[g]);
    // unused channels pass vacuously
    assign ok[g] = !need_i[g] || cond_hit(kind, cur_i[g], prev_i[g], prev_ok_i);
  end

  assign all_o = &ok;
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic strobe_i,
  input  logic match_i,
  output logic armed_o,
  output logic trig_o
);
  logic fire;
  assign fire = armed_o && strobe_i && !arm_i && match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      trig_o  <= 1'b0;
    end else begin
      trig_o <= fire;
      if (arm_i)     armed_o <= 1'b1;
      else if (fire) armed_o <= 1'b0;
    end
  end

  // R7
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  // R7
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !armed_o || $past(arm_i));

  // R8
  arm_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !trig_o);
endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              strobe_i,
  input  logic [NUM_CH-1:0] sample_i,
  input  logic [NUM_CH-1:0] chan_mask_i,
  input  logic [NUM_CH-1:0] en_mask_i,
  input  logic [NUM_CH-1:0] level_mask_i,
  input  logic [NUM_CH-1:0] pol_mask_i,
  output logic              trig_o
);
  localparam int unsigned MW = NUM_CH;

  logic [MW-1:0] prev_q;
  logic [MW-1:0] need;
  logic          prev_ok;
  logic          match;
  logic          armed;

  assign need = chan_mask_i & en_mask_i;

  trig_hist #(.W(MW)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (arm_i),
    .load_i  (strobe_i && !arm_i),
    .d_i     (sample_i),
    .q_o     (prev_q),
    .valid_o (prev_ok)
  );

  trig_cond #(.W(MW)) u_cond (
    .cur_i     (sample_i),
    .prev_i    (prev_q),
    .prev_ok_i (prev_ok),
    .need_i    (need),
    .level_i   (level_mask_i),
    .pol_i     (pol_mask_i),
    .all_o     (match)
  );

  trig_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .strobe_i (strobe_i),
    .match_i  (match),
    .armed_o  (armed),
    .trig_o   (trig_o)
  );

  // R1
  fire_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(armed) && $past(strobe_i));

  // R4
  fire_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !match) |=> !trig_o);
endmodule

// File: tb/trig_match_tb.sv
module trig_match_tb;
  typedef struct packed {
    logic [15:0] chan;
    logic [15:0] en;
    logic [15:0] lvl;
    logic [15:0] pol;
    logic [15:0] s0;
    logic [15:0] s1;
    logic        e0;
    logic        e1;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0001, 1'b0, 1'b1, 8'd2}, // R2 high
    '{16'h0020, 16'h0020, 16'h0020, 16'h0000, 16'h0020, 16'h0000, 1'b0, 1'b1, 8'd2}, // R2 low
    '{16'h0008, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0008, 1'b0, 1'b1, 8'd3}, // R3 rising
    '{16'h8000, 16'h8000, 16'h0000, 16'h8000, 16'h8000, 16'h0000, 1'b0, 1'b1, 8'd3}, // R3 falling
    '{16'h8000, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b0, 8'd3}, // R3 wrong dir
    '{16'h0008, 16'h0008, 16'h0000, 16'h0000, 16'h0008, 16'h0008, 1'b0, 1'b0, 8'd6}, // R6 no false edge
    '{16'h0003, 16'h0003, 16'h0003, 16'h0003, 16'h0001, 16'h0003, 1'b0, 1'b1, 8'd4}, // R4 AND
    '{16'h0003, 16'h0001, 16'h0003, 16'h0003, 16'h0001, 16'h0003, 1'b1, 1'b0, 8'd4}, // R4 en clear
    '{16'h0001, 16'h0003, 16'h0003, 16'h0003, 16'h0001, 16'h0001, 1'b1, 1'b0, 8'd4}, // R4 chan clear
    '{16'hFFFF, 16'h0000, 16'h1234, 16'h00FF, 16'h1234, 16'h4321, 1'b1, 1'b0, 8'd5}, // R5
    '{16'h0204, 16'h0204, 16'h0004, 16'h0000, 16'h0000, 16'h0200, 1'b0, 1'b1, 8'd4}, // R4 mixed
    '{16'h0204, 16'h0204, 16'h0004, 16'h0000, 16'h0000, 16'h0204, 1'b0, 1'b0, 8'd4}  // R4 mixed fail
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [15:0] chan_mask_i = '0;
  logic [15:0] en_mask_i = '0;
  logic [15:0] level_mask_i = '0;
  logic [15:0] pol_mask_i = '0;
  logic        trig_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_match u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .strobe_i     (strobe_i),
    .sample_i     (sample_i),
    .chan_mask_i  (chan_mask_i),
    .en_mask_i    (en_mask_i),
    .level_mask_i (level_mask_i),
    .pol_mask_i   (pol_mask_i),
    .trig_o       (trig_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s trig_o act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [15:0] c, e, l, p);
    @(negedge clk);
    chan_mask_i = c; en_mask_i = e; level_mask_i = l; pol_mask_i = p;
  endtask

  task automatic do_arm();
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
  endtask

  // strobe one sample; trig_o is sampled one negedge later
  task automatic strobe(input logic [15:0] s);
    @(negedge clk); sample_i = s; strobe_i = 1'b1;
    @(negedge clk); strobe_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(trig_o, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check(trig_o, 1'b0, "R1 after reset");
    // R1: enable mask zero would fire at once if armed
    cfg(16'hFFFF, 16'h0000, 16'h0000, 16'h0000);
    strobe(16'h0000);
    check(trig_o, 1'b0, "R1 strobe before arm");
    strobe(16'hFFFF);
    check(trig_o, 1'b0, "R1 second strobe before arm");

    for (int i = 0; i < NV; i++) begin
      cfg(VECS[i].chan, VECS[i].en, VECS[i].lvl, VECS[i].pol);
      do_arm();
      strobe(VECS[i].s0);
      check(trig_o, VECS[i].e0, $sformatf("R%0d vec%0d s0", VECS[i].req, i));
      strobe(VECS[i].s1);
      check(trig_o, VECS[i].e1, $sformatf("R%0d vec%0d s1", VECS[i].req, i));
    end

    // R9: samples between strobes are not recorded
    cfg(16'h0008, 16'h0008, 16'h0000, 16'h0000);
    do_arm();
    strobe(16'h0000);
    check(trig_o, 1'b0, "R9 first strobe");
    @(negedge clk); sample_i = 16'h0008;
    repeat (3) @(negedge clk);
    check(trig_o, 1'b0, "R9 no strobe no fire");
    strobe(16'h0008);
    check(trig_o, 1'b1, "R9 edge across strobes");
    @(negedge clk);
    check(trig_o, 1'b0, "R7 pulse one cycle");

    // R7: quiet after firing until re-armed
    strobe(16'h0000);
    strobe(16'h0008);
    check(trig_o, 1'b0, "R7 quiet after fire");
    do_arm();
    strobe(16'h0000);
    strobe(16'h0008);
    check(trig_o, 1'b1, "R7 fires after re-arm");

    // R8: coincident arm and strobe, no channel enabled
    cfg(16'hFFFF, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk); arm_i = 1'b1; strobe_i = 1'b1; sample_i = 16'h0000;
    @(negedge clk); arm_i = 1'b0; strobe_i = 1'b0;
    check(trig_o, 1'b0, "R8 coincident strobe not evaluated");
    strobe(16'h0000);
    check(trig_o, 1'b1, "R8 next strobe evaluated");

    // R8: coincident strobe not recorded as history
    cfg(16'h0008, 16'h0008, 16'h0000, 16'h0000);
    @(negedge clk); arm_i = 1'b1; strobe_i = 1'b1; sample_i = 16'h0000;
    @(negedge clk); arm_i = 1'b0; strobe_i = 1'b0;
    check(trig_o, 1'b0, "R8 coincident cycle");
    strobe(16'h0008);
    check(trig_o, 1'b0, "R8 coincident strobe not stored");
    strobe(16'h0000);
    strobe(16'h0008);
    check(trig_o, 1'b1, "R3 rising after history");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule